// File: doc/BRIEF.md
# Multi-Block Card Transfer Sequencer

This block sequences block-oriented data moves between a host-side FIFO and a memory card. Software loads a block length, a direction and a mode, then pulses a start input. While a block is in progress the sequencer grants the serial engine permission to move bytes. It counts each byte the engine reports and raises an internal boundary event once a full block has moved.

Three modes are offered. Single-block mode finishes after one block. Manual multi-block mode parks at every block boundary. Software must then either write a control word with both the continue and data-enable bits set, or write the abort bit. The abort ends the sequence at once and requests the stop command. Auto mode runs a preset number of blocks with no software handshake and requests the stop command after the last one.

Independently of the mode, the sequencer holds off the transfer whenever the FIFO cannot take or supply data. In a receive this happens when the FIFO is full, and in a send when it is empty. The transfer resumes when software writes the continue bit. A status byte reports busy, the two stall causes and the boundary wait.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, `status` is 8'h00 and both `xfer_en` and `stop_req` are 0.
- R2: A `start` pulse while idle gives `status` = 8'h80 and `xfer_en` = 1 from the next cycle. A `start` while busy is ignored and does not restart the byte count.
- R3: A block ends on the `blk_len`-th accepted `byte_done` strobe. A `blk_len` of 0 selects the default length of 512 bytes.
- R4: With `multi_blk` = 0, the end of the first block returns the sequencer to idle (`status` = 8'h00) without a `stop_req` pulse.
- R5: In manual multi-block mode (`multi_blk` = 1, `auto_mode` = 0), every block end parks the sequencer: `status` = 8'h81 (bit 7 busy, bit 0 boundary wait) and `xfer_en` = 0.
- R6: While parked, only a control write (`ctl_wr` = 1) with both `ctl_cont` and `ctl_den` at 1 resumes the transfer (`status` = 8'h80). A write with just one of the two bits leaves it parked.
- R7: A control write with `ctl_abort` = 1 while busy drives `status` to 8'h00 and `xfer_en` to 0 on the next cycle, and raises `stop_req` for exactly one cycle. Abort wins over `ctl_cont` in the same write. An abort while idle gives no pulse. A new start after an abort begins a fresh block count.
- R8: In auto mode (`multi_blk` = 1, `auto_mode` = 1), blocks follow each other without parking. After `blk_count` blocks the sequencer goes idle with one `stop_req` pulse. A count of 0 behaves as 1.
- R9: In a receive (`dir_rx` = 1), `fifo_full` during a transfer stalls it: `status` = 8'hC0 (bit 6 FIFO-full) and `xfer_en` = 0. A control write with `ctl_cont` = 1 resumes it, and an abort clears bit 6. `fifo_full` has no effect while parked.
- R10: In a send (`dir_rx` = 0), `fifo_empty` during a transfer stalls it: `status` = 8'h82 (bit 1). A `ctl_cont` write resumes it, and `fifo_full` has no effect in a send.
- R11: A `byte_done` strobe while `xfer_en` = 0 is ignored by the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command sequence (pulse) |
| multi_blk | input | 1 | 1 = multi-block, 0 = single block |
| auto_mode | input | 1 | 1 = preset block count, no per-block handshake |
| dir_rx | input | 1 | 1 = card to FIFO, 0 = FIFO to card |
| blk_len | input | LEN_W | Bytes per block, 0 selects DEF_LEN |
| blk_count | input | CNT_W | Block count for auto mode |
| ctl_wr | input | 1 | Control write strobe |
| ctl_cont | input | 1 | Continue bit of the control write |
| ctl_den | input | 1 | Data-enable bit of the control write |
| ctl_abort | input | 1 | Abort bit of the control write |
| fifo_full | input | 1 | Host FIFO full |
| fifo_empty | input | 1 | Host FIFO empty |
| byte_done | input | 1 | Serial engine moved one byte |
| xfer_en | output | 1 | Byte movement permitted |
| stop_req | output | 1 | One-cycle request to issue the stop command |
| status | output | 8 | {busy, fifo-full stall, 4'b0, fifo-empty stall, boundary wait} |

## Verification
A wrong state register shows on `status` and `xfer_en` one clock after the stimulus, because both decode the registered state directly. A corrupted byte counter stays hidden until the next block end. It then shows as a boundary wait or an idle return arriving one or more strobes early or late, so the directed runs check `status` after every partial and final strobe. A block counter error only appears when auto mode reaches its last block, as a missing, early or late `stop_req`.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_XFER  = 2'd1,
      ST_STALL = 2'd2,
      ST_BWAIT = 2'd3
   } seq_state_t;

   localparam int STAT_W       = 8;
   localparam int STAT_BUSY    = 7;
   localparam int STAT_RXFULL  = 6;
   localparam int STAT_TXEMPTY = 1;
   localparam int STAT_BWAIT   = 0;

endpackage

// File: rtl/blkxfer_bytecnt.sv
module blkxfer_bytecnt #(
   parameter int LEN_W   = 12,
   parameter int DEF_LEN = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [LEN_W-1:0] blk_len,
   output logic             boundary
);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] eff_len;
   logic [LEN_W-1:0] last_idx;

   assign eff_len  = (blk_len == '0) ? LEN_W'(DEF_LEN) : blk_len;
   assign last_idx = eff_len - LEN_W'(1);
   assign boundary = adv && (cnt_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= boundary ? '0 : cnt_q + LEN_W'(1);
      end
   end

   // R3: the count never passes the last byte of the block
   a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt_q < eff_len));

   // R11: a cleared counter stays cleared until bytes are accepted
   a_r11_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/blkxfer_blkcnt.sv
module blkxfer_blkcnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);

   logic [CNT_W-1:0] left_q;

   assign last = (left_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= load_val;
      end else if (dec) begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   // R8: a decrement only happens with at least two blocks left
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> (left_q >= CNT_W'(2)));

endmodule

// File: rtl/blkxfer_fsm.sv
module blkxfer_fsm
   import blkxfer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       multi_blk,
   input  logic       auto_sel,
   input  logic       dir_rx,
   input  logic       fifo_full,
   input  logic       fifo_empty,
   input  logic       ctl_wr,
   input  logic       ctl_cont,
   input  logic       ctl_den,
   input  logic       ctl_abort,
   input  logic       boundary,
   input  logic       last_blk,
   output seq_state_t state,
   output logic       dir_q,
   output logic       cnt_load,
   output logic       blk_dec,
   output logic       stop_req
);

   seq_state_t state_q, state_d;
   logic       multi_q, auto_q;
   logic       abort_acc, auto_fin, stall_hit;

   assign state     = state_q;
   assign abort_acc = ctl_wr && ctl_abort && (state_q != ST_IDLE);
   assign stall_hit = dir_q ? fifo_full : fifo_empty;

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      blk_dec  = 1'b0;
      auto_fin = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d  = ST_XFER;
               cnt_load = 1'b1;
            end
         end
         ST_XFER: begin
            if (abort_acc) begin
               state_d = ST_IDLE;
            end else if (boundary) begin
               if (!multi_q) begin
                  state_d = ST_IDLE;
               end else if (auto_q) begin
                  if (last_blk) begin
                     state_d  = ST_IDLE;
                     auto_fin = 1'b1;
                  end else begin
                     blk_dec = 1'b1;
                  end
               end else begin
                  state_d = ST_BWAIT;
               end
            end else if (stall_hit) begin
               state_d = ST_STALL;
            end
         end
         ST_STALL: begin
            if (abort_acc) begin
               state_d = ST_IDLE;
            end else if (ctl_wr && ctl_cont) begin
               state_d = ST_XFER;
            end
         end
         ST_BWAIT: begin
            if (abort_acc) begin
               state_d = ST_IDLE;
            end else if (ctl_wr && ctl_cont && ctl_den) begin
               state_d = ST_XFER;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         multi_q  <= 1'b0;
         auto_q   <= 1'b0;
         dir_q    <= 1'b0;
         stop_req <= 1'b0;
      end else begin
         state_q  <= state_d;
         stop_req <= abort_acc || auto_fin;
         if (cnt_load) begin
            multi_q <= multi_blk;
            auto_q  <= auto_sel && multi_blk;
            dir_q   <= dir_rx;
         end
      end
   end

   // R6: a parked sequencer stays parked without a full handshake or abort
   a_r6_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BWAIT && !(ctl_wr && ((ctl_cont && ctl_den) || ctl_abort)))
      |=> (state_q == ST_BWAIT));

   // R9: a stall is left only through a continue or abort write
   a_r9_stall_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STALL && !ctl_wr) |=> (state_q == ST_STALL));

   // R4: a single-block sequence never parks at a boundary
   a_r4_single_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_XFER && boundary && !multi_q) |=> (state_q == ST_IDLE && !stop_req));

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int LEN_W   = 12,
   parameter int DEF_LEN = 512,
   parameter int CNT_W   = 16,
   parameter bit AUTO_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             multi_blk,
   input  logic             auto_mode,
   input  logic             dir_rx,
   input  logic [LEN_W-1:0] blk_len,
   input  logic [CNT_W-1:0] blk_count,
   input  logic             ctl_wr,
   input  logic             ctl_cont,
   input  logic             ctl_den,
   input  logic             ctl_abort,
   input  logic             fifo_full,
   input  logic             fifo_empty,
   input  logic             byte_done,
   output logic             xfer_en,
   output logic             stop_req,
   output logic [7:0]       status
);

   localparam int LEN_MAX = (1 << LEN_W) - 1;

   if (LEN_W < 2) begin : g_bad_len_w
      $error("blkxfer_seq: LEN_W must be at least 2");
   end
   if (DEF_LEN < 1 || DEF_LEN > LEN_MAX) begin : g_bad_def_len
      $error("blkxfer_seq: DEF_LEN must fit in LEN_W bits and be nonzero");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("blkxfer_seq: CNT_W must be at least 1");
   end
   if (STAT_W != 8) begin : g_bad_stat_w
      $error("blkxfer_seq: status layout expects 8 bits");
   end

   seq_state_t state;
   logic       dir_q, cnt_load, blk_dec, boundary, last_blk, auto_sel;
   logic       busy, rx_stall, tx_stall, bwait;

   assign xfer_en = (state == ST_XFER);

   blkxfer_bytecnt #(
      .LEN_W  (LEN_W),
      .DEF_LEN(DEF_LEN)
   ) u_bytecnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state == ST_IDLE),
      .adv     (xfer_en && byte_done),
      .blk_len (blk_len),
      .boundary(boundary)
   );

   if (AUTO_EN) begin : g_auto
      assign auto_sel = auto_mode;
      blkxfer_blkcnt #(
         .CNT_W(CNT_W)
      ) u_blkcnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (cnt_load),
         .load_val(blk_count),
         .dec     (blk_dec),
         .last    (last_blk)
      );
   end else begin : g_no_auto
      assign auto_sel = 1'b0;
      assign last_blk = 1'b1;
   end

   blkxfer_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .multi_blk (multi_blk),
      .auto_sel  (auto_sel),
      .dir_rx    (dir_rx),
      .fifo_full (fifo_full),
      .fifo_empty(fifo_empty),
      .ctl_wr    (ctl_wr),
      .ctl_cont  (ctl_cont),
      .ctl_den   (ctl_den),
      .ctl_abort (ctl_abort),
      .boundary  (boundary),
      .last_blk  (last_blk),
      .state     (state),
      .dir_q     (dir_q),
      .cnt_load  (cnt_load),
      .blk_dec   (blk_dec),
      .stop_req  (stop_req)
   );

   assign busy     = (state != ST_IDLE);
   assign rx_stall = (state == ST_STALL) &&  dir_q;
   assign tx_stall = (state == ST_STALL) && !dir_q;
   assign bwait    = (state == ST_BWAIT);

   always_comb begin
      status               = '0;
      status[STAT_BUSY]    = busy;
      status[STAT_RXFULL]  = rx_stall;
      status[STAT_TXEMPTY] = tx_stall;
      status[STAT_BWAIT]   = bwait;
   end

   // R7: an abort while busy ends the sequence and requests the stop command
   a_r7_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_abort && status[STAT_BUSY]) |=> (!status[STAT_BUSY] && stop_req));

   // R7: the stop request lasts a single cycle
   a_r7_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !stop_req);

   // R1: a stop request is only raised as the sequence leaves busy
   a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> !status[STAT_BUSY]);

   // R2: a start while idle opens the transfer window on the next cycle
   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !status[STAT_BUSY]) |=> (xfer_en && status == 8'h80));

   // R9: the status stall bits are never both set
   a_r9_one_stall: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({status[STAT_RXFULL], status[STAT_TXEMPTY], status[STAT_BWAIT]}));

endmodule

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;

   localparam int LEN_W = 12;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start, multi_blk, auto_mode, dir_rx;
   logic [LEN_W-1:0] blk_len;
   logic [CNT_W-1:0] blk_count;
   logic             ctl_wr, ctl_cont, ctl_den, ctl_abort;
   logic             fifo_full, fifo_empty, byte_done;
   logic             xfer_en, stop_req;
   logic [7:0]       status;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   blkxfer_seq #(.LEN_W(LEN_W), .DEF_LEN(512), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .multi_blk(multi_blk),
      .auto_mode(auto_mode), .dir_rx(dir_rx), .blk_len(blk_len),
      .blk_count(blk_count), .ctl_wr(ctl_wr), .ctl_cont(ctl_cont),
      .ctl_den(ctl_den), .ctl_abort(ctl_abort), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .byte_done(byte_done), .xfer_en(xfer_en),
      .stop_req(stop_req), .status(status)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      tick();
      start = 1'b0;
   endtask

   task automatic ctl(input logic c, input logic d, input logic a);
      ctl_wr = 1'b1; ctl_cont = c; ctl_den = d; ctl_abort = a;
      tick();
      ctl_wr = 1'b0; ctl_cont = 1'b0; ctl_den = 1'b0; ctl_abort = 1'b0;
   endtask

   task automatic bytes(input int n);
      for (int i = 0; i < n; i++) begin
         byte_done = 1'b1;
         tick();
      end
      byte_done = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 status", status, 8'h00);
      check("R1 xfer_en", xfer_en, 0);
      check("R1 stop_req", stop_req, 0);
   endtask

   task automatic t_single();
      blk_len = 4; multi_blk = 0; auto_mode = 0; dir_rx = 1;
      pulse_start();
      check("R2 busy after start", status, 8'h80);
      check("R2 xfer_en after start", xfer_en, 1);
      bytes(2);
      pulse_start();
      check("R2 start ignored while busy", status, 8'h80);
      bytes(1);
      check("R3 block not yet ended", status, 8'h80);
      bytes(1);
      check("R4 single block idle", status, 8'h00);
      check("R4 no stop pulse", stop_req, 0);
      check("R4 xfer_en off", xfer_en, 0);
   endtask

   task automatic t_manual();
      blk_len = 3; multi_blk = 1; auto_mode = 0; dir_rx = 1;
      pulse_start();
      bytes(3);
      check("R5 parked status", status, 8'h81);
      check("R5 parked xfer_en", xfer_en, 0);
      ctl(1, 0, 0);
      check("R6 continue alone", status, 8'h81);
      ctl(0, 1, 0);
      check("R6 data-enable alone", status, 8'h81);
      ctl(1, 1, 0);
      check("R6 resume status", status, 8'h80);
      check("R6 resume xfer_en", xfer_en, 1);
      bytes(3);
      check("R5 parked again", status, 8'h81);
      ctl(1, 1, 1);
      check("R7 abort status", status, 8'h00);
      check("R7 abort stop pulse", stop_req, 1);
      tick();
      check("R7 stop pulse one cycle", stop_req, 0);
      ctl(0, 0, 1);
      check("R7 idle abort no pulse", stop_req, 0);
      pulse_start();
      bytes(1);
      ctl(0, 0, 1);
      check("R7 mid-block abort", status, 8'h00);
      check("R7 mid-block stop", stop_req, 1);
      pulse_start();
      bytes(2);
      check("R7 fresh count after abort", status, 8'h80);
      bytes(1);
      check("R7 fresh block ends", status, 8'h81);
      ctl(0, 0, 1);
   endtask

   task automatic t_auto();
      blk_len = 2; multi_blk = 1; auto_mode = 1; dir_rx = 1; blk_count = 3;
      pulse_start();
      bytes(2);
      check("R8 no park block 1", status, 8'h80);
      check("R8 xfer_en block 1", xfer_en, 1);
      check("R8 no stop block 1", stop_req, 0);
      bytes(2);
      check("R8 no park block 2", status, 8'h80);
      bytes(2);
      check("R8 idle after last", status, 8'h00);
      check("R8 stop after last", stop_req, 1);
      tick();
      check("R8 stop one cycle", stop_req, 0);
      blk_count = 0;
      pulse_start();
      bytes(2);
      check("R8 zero count as one", status, 8'h00);
      check("R8 zero count stop", stop_req, 1);
      tick();
      auto_mode = 0;
   endtask

   task automatic t_rx_stall();
      blk_len = 4; multi_blk = 1; auto_mode = 0; dir_rx = 1;
      pulse_start();
      bytes(1);
      fifo_full = 1;
      tick();
      check("R9 rx stall status", status, 8'hC0);
      check("R9 rx stall xfer_en", xfer_en, 0);
      byte_done = 1;
      tick();
      byte_done = 0;
      fifo_full = 0;
      ctl(1, 0, 0);
      check("R9 resume on continue", status, 8'h80);
      bytes(2);
      check("R11 stalled strobe ignored", status, 8'h80);
      bytes(1);
      check("R11 block end after 4", status, 8'h81);
      fifo_full = 1;
      tick();
      check("R9 full ignored while parked", status, 8'h81);
      ctl(1, 1, 0);
      check("R9 resume from park", status, 8'h80);
      tick();
      check("R9 stall again", status, 8'hC0);
      ctl(0, 0, 1);
      check("R9 abort clears full flag", status, 8'h00);
      fifo_full = 0;
      tick();
   endtask

   task automatic t_tx_stall();
      blk_len = 2; multi_blk = 0; auto_mode = 0; dir_rx = 0;
      fifo_full = 1;
      pulse_start();
      tick();
      check("R10 full ignored in send", status, 8'h80);
      fifo_full = 0;
      bytes(1);
      fifo_empty = 1;
      tick();
      check("R10 tx stall status", status, 8'h82);
      check("R10 tx stall xfer_en", xfer_en, 0);
      fifo_empty = 0;
      ctl(1, 0, 0);
      check("R10 resume on continue", status, 8'h80);
      bytes(1);
      check("R10 send completes", status, 8'h00);
   endtask

   task automatic t_default_len();
      blk_len = 0; multi_blk = 0; auto_mode = 0; dir_rx = 1;
      pulse_start();
      bytes(511);
      check("R3 default length not reached", status, 8'h80);
      bytes(1);
      check("R3 default length 512", status, 8'h00);
   endtask

   function automatic void summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired before the end of the run");
      summary();
      $finish;
   end

   initial begin
      rst_n = 0; start = 0; multi_blk = 0; auto_mode = 0; dir_rx = 1;
      blk_len = 4; blk_count = 1; ctl_wr = 0; ctl_cont = 0; ctl_den = 0;
      ctl_abort = 0; fifo_full = 0; fifo_empty = 0; byte_done = 0;
      tick(3);
      t_reset();
      rst_n = 1;
      tick();
      t_single();
      t_manual();
      t_auto();
      t_rx_stall();
      t_tx_stall();
      t_default_len();
      summary();
      $finish;
   end

endmodule